// File: doc/BRIEF.md
# DMA Request and Panic Generator

This block sits between a serial master's byte FIFOs and two external DMA channels: one channel fills the transmit FIFO and the other empties the receive FIFO. It watches both fill levels against four programmable 8-bit thresholds. From them it raises a data request and a higher-priority panic request toward each channel. The transmit side asks for data while the FIFO is low. The receive side asks while the FIFO is high, and it also asks once the frame is complete and bytes are still left in the FIFO.

The DMA side always moves 32-bit words, while the frame length is a byte count. The block splits each incoming word into FIFO bytes, starting with the lowest byte. It gathers received bytes into words in the same order. It also counts bytes against the length, so it can drop the unused tail of the final transmit word, zero-fill the final receive word, and request that transfer-active be cleared when the frame ends. The frame ends either when the last received word has been handed over or when the DMA side signals frame end.

Top module: `dma_req_gen`

## Requirements
- R1: After reset the thresholds are 0x30 for RX panic, 0x20 for RX request, 0x10 for TX panic and 0x20 for TX request. A pulse on `cfg_wr` loads all four from `cfg_wdata`, using these fields: [31:24] RX panic, [23:16] RX request, [15:8] TX panic, [7:0] TX request.
- R2: `tx_dreq` is high when the TX level is less than or equal to the TX request threshold. It updates one clock after its inputs change.
- R3: `tx_panic` is high when the TX level is less than or equal to the TX panic threshold. It updates one clock after its inputs change.
- R4: `rx_dreq` is high when the RX level is strictly greater than the RX request threshold. It updates one clock after its inputs change.
- R5: `rx_panic` is high when the RX level is strictly greater than the RX panic threshold. It updates one clock after its inputs change.
- R6: `rx_dreq` is also high once the frame has finished and the RX level is non-zero. The frame counts as finished when all `xfer_len` bytes have been pushed to the TX FIFO and the TX level is zero. This path settles within three clocks.
- R7: While `dma_en` is low, all four request and panic outputs stay low. No word is accepted, no byte is pushed and no byte is popped. The byte counters stay cleared whenever `dma_en` or `xfer_active` is low.
- R8: An accepted TX word is pushed as bytes, lowest byte first. One byte is pushed per clock, starting the clock after acceptance. Pushing pauses while `tx_full` is high, and the pending byte is held.
- R9: Once the byte count reaches `xfer_len`, the unused upper bytes of the current TX word are discarded, and `dma_wr_ready` stays low for the rest of the frame.
- R10: RX bytes are popped only when the RX level is non-zero. They are packed lowest byte first into a word, and the word is offered on `dma_rd_valid` after four bytes.
- R11: When the byte count runs out partway through a word, the final RX word is offered with its unfilled upper bytes set to zero.
- R12: `ta_clear` is a one-clock pulse in the clock after `frame_end` is high, or after the final RX word is handed over. If both happen in the same clock, a single pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_en | input | 1 | DMA mode enable |
| xfer_active | input | 1 | Transfer-active state |
| xfer_len | input | 16 | Frame length in bytes |
| frame_end | input | 1 | Frame-end pulse from the DMA side |
| cfg_wr | input | 1 | Threshold load strobe |
| cfg_wdata | input | 32 | Packed threshold values |
| tx_level | input | 8 | TX FIFO fill level |
| rx_level | input | 8 | RX FIFO fill level |
| tx_full | input | 1 | TX FIFO full |
| tx_push | output | 1 | Push a byte into the TX FIFO |
| tx_byte | output | 8 | Byte pushed into the TX FIFO |
| rx_byte | input | 8 | Head byte of the RX FIFO (first-word fall-through) |
| rx_pop | output | 1 | Pop the RX FIFO head |
| dma_wr_valid | input | 1 | TX word offered by the DMA channel |
| dma_wr_data | input | 32 | TX word |
| dma_wr_ready | output | 1 | TX word accepted |
| dma_rd_valid | output | 1 | RX word available |
| dma_rd_data | output | 32 | RX word |
| dma_rd_ready | input | 1 | RX word taken by the DMA channel |
| tx_dreq | output | 1 | TX data request |
| rx_dreq | output | 1 | RX data request |
| tx_panic | output | 1 | TX priority panic |
| rx_panic | output | 1 | RX priority panic |
| ta_clear | output | 1 | Request to clear transfer-active |

## Verification
Two events can request the end of a frame in the same clock: a `frame_end` pulse from the DMA side, and the handshake of the last receive word.

The bench holds a short final word pending with `dma_rd_ready` low. It then raises `dma_rd_ready` and `frame_end` on the same edge. It expects `ta_clear` high for exactly one clock, and it expects the zero-padded word.

The bench also lets the threshold path and the frame-finished path of the RX request compete. It holds the RX level below the threshold, confirms `rx_dreq` stays low until the transmit side drains, and then sees `rx_dreq` rise from the finished condition alone.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;

  localparam int THR_W = 8;

  // Field layout of the threshold load word, most significant first.
  typedef struct packed {
    logic [THR_W-1:0] rx_panic;
    logic [THR_W-1:0] rx_req;
    logic [THR_W-1:0] tx_panic;
    logic [THR_W-1:0] tx_req;
  } thr_cfg_t;

  localparam thr_cfg_t THR_RESET = '{
    rx_panic: 8'h30, rx_req: 8'h20, tx_panic: 8'h10, tx_req: 8'h20
  };

  // The TX side asks for data while the FIFO is at or below the mark.
  function automatic logic tx_low(input logic [THR_W-1:0] lvl,
                                  input logic [THR_W-1:0] thr);
    return lvl <= thr;
  endfunction

  // The RX side asks while the FIFO is strictly above the mark.
  function automatic logic rx_high(input logic [THR_W-1:0] lvl,
                                   input logic [THR_W-1:0] thr);
    return lvl > thr;
  endfunction

  // Bytes of the next word that still belong to the frame.
  function automatic int unsigned chunk_bytes(input int unsigned remaining,
                                              input int unsigned per_word);
    return (remaining < per_word) ? remaining : per_word;
  endfunction

endpackage

// File: rtl/dreq_thresh.sv
module dreq_thresh
  import dmareq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dma_en,
  input  logic             cfg_wr,
  input  logic [31:0]      cfg_wdata,
  input  logic [THR_W-1:0] tx_level,
  input  logic [THR_W-1:0] rx_level,
  input  logic             frame_fin,
  output logic             tx_dreq,
  output logic             rx_dreq,
  output logic             tx_panic,
  output logic             rx_panic
);

  thr_cfg_t cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg <= THR_RESET;
    else if (cfg_wr) cfg <= thr_cfg_t'(cfg_wdata);
  end

  logic rx_tail;
  assign rx_tail = frame_fin && (rx_level != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_dreq  <= 1'b0;
      rx_dreq  <= 1'b0;
      tx_panic <= 1'b0;
      rx_panic <= 1'b0;
    end else begin
      tx_dreq  <= dma_en && tx_low(tx_level, cfg.tx_req);
      tx_panic <= dma_en && tx_low(tx_level, cfg.tx_panic);
      rx_dreq  <= dma_en && (rx_high(rx_level, cfg.rx_req) || rx_tail);
      rx_panic <= dma_en && rx_high(rx_level, cfg.rx_panic);
    end
  end

  assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dma_en) |-> !(tx_dreq || rx_dreq || tx_panic || rx_panic));

  assert_tx_panic_nested_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_panic && ($past(cfg.tx_panic) <= $past(cfg.tx_req))) |-> tx_dreq);

  assert_rx_panic_nested_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_panic && ($past(cfg.rx_panic) >= $past(cfg.rx_req))) |-> rx_dreq);

endmodule

// File: rtl/dreq_tx_unpack.sv
module dreq_tx_unpack
  import dmareq_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic [LEN_W-1:0]        len,
  input  logic                    wr_valid,
  input  logic [8*WORD_BYTES-1:0] wr_data,
  output logic                    wr_ready,
  input  logic                    tx_full,
  output logic                    tx_push,
  output logic [7:0]              tx_byte,
  output logic                    all_sent
);

  localparam int LEFT_W = $clog2(WORD_BYTES + 1);

  logic [LEN_W-1:0]        taken;
  logic [LEFT_W-1:0]       left;
  logic [8*WORD_BYTES-1:0] word;
  logic [LEN_W-1:0]        remaining;
  logic [LEFT_W-1:0]       chunk;
  logic                    accept;

  assign remaining = len - taken;
  assign chunk     = LEFT_W'(chunk_bytes(32'(remaining), WORD_BYTES));
  assign wr_ready  = run && (left == '0) && (remaining != '0);
  assign accept    = wr_valid && wr_ready;
  assign tx_push   = run && (left != '0) && !tx_full;
  assign tx_byte   = word[7:0];
  assign all_sent  = run && (remaining == '0) && (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken <= '0;
      left  <= '0;
      word  <= '0;
    end else if (!run) begin
      taken <= '0;
      left  <= '0;
      word  <= '0;
    end else if (accept) begin
      word  <= wr_data;
      left  <= chunk;
      taken <= taken + LEN_W'(chunk);
    end else if (tx_push) begin
      word  <= word >> 8;
      left  <= left - 1'b1;
    end
  end

  assert_hold_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !tx_push);

  assert_low_byte_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (tx_byte == $past(wr_data[7:0])));

  assert_within_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $stable(len)) |-> (taken <= len));

endmodule

// File: rtl/dreq_rx_pack.sv
module dreq_rx_pack #(
  parameter int LEN_W      = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic [LEN_W-1:0]        len,
  input  logic                    rx_nonempty,
  input  logic [7:0]              rx_byte,
  output logic                    rx_pop,
  output logic                    rd_valid,
  output logic [8*WORD_BYTES-1:0] rd_data,
  input  logic                    rd_ready,
  output logic                    last_handoff
);

  localparam int LEFT_W = $clog2(WORD_BYTES + 1);

  logic [LEFT_W-1:0]       have;
  logic [LEN_W-1:0]        got;
  logic [8*WORD_BYTES-1:0] acc;
  logic                    word_ready;
  logic                    count_done;
  logic                    handoff;

  assign count_done   = (got == len);
  assign word_ready   = (have == LEFT_W'(WORD_BYTES)) || ((have != '0) && count_done);
  assign rx_pop       = run && rx_nonempty && !word_ready && !count_done;
  assign rd_valid     = run && word_ready;
  assign rd_data      = acc;
  assign handoff      = rd_valid && rd_ready;
  assign last_handoff = handoff && count_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have <= '0;
      got  <= '0;
      acc  <= '0;
    end else if (!run) begin
      have <= '0;
      got  <= '0;
      acc  <= '0;
    end else if (handoff) begin
      have <= '0;
      acc  <= '0;
    end else if (rx_pop) begin
      for (int b = 0; b < WORD_BYTES; b++) begin
        if (have == LEFT_W'(b)) acc[8*b +: 8] <= rx_byte;
      end
      have <= have + 1'b1;
      got  <= got + 1'b1;
    end
  end

  assert_pop_needs_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_nonempty |-> !rx_pop);

  assert_short_word_padded_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && (have == LEFT_W'(1))) |-> (acc[8*WORD_BYTES-1:8] == '0));

endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
  import dmareq_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int WORD_BYTES = 4,
  localparam int WORD_W    = 8 * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_en,
  input  logic              xfer_active,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              frame_end,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  input  logic [THR_W-1:0]  tx_level,
  input  logic [THR_W-1:0]  rx_level,
  input  logic              tx_full,
  output logic              tx_push,
  output logic [7:0]        tx_byte,
  input  logic [7:0]        rx_byte,
  output logic              rx_pop,
  input  logic              dma_wr_valid,
  input  logic [WORD_W-1:0] dma_wr_data,
  output logic              dma_wr_ready,
  output logic              dma_rd_valid,
  output logic [WORD_W-1:0] dma_rd_data,
  input  logic              dma_rd_ready,
  output logic              tx_dreq,
  output logic              rx_dreq,
  output logic              tx_panic,
  output logic              rx_panic,
  output logic              ta_clear
);

  logic run;
  logic all_sent;
  logic last_handoff;
  logic frame_fin;

  assign run = dma_en && xfer_active;

  dreq_tx_unpack #(.LEN_W(LEN_W), .WORD_BYTES(WORD_BYTES)) u_tx (
    .clk(clk), .rst_n(rst_n), .run(run), .len(xfer_len),
    .wr_valid(dma_wr_valid), .wr_data(dma_wr_data), .wr_ready(dma_wr_ready),
    .tx_full(tx_full), .tx_push(tx_push), .tx_byte(tx_byte), .all_sent(all_sent)
  );

  dreq_rx_pack #(.LEN_W(LEN_W), .WORD_BYTES(WORD_BYTES)) u_rx (
    .clk(clk), .rst_n(rst_n), .run(run), .len(xfer_len),
    .rx_nonempty(rx_level != '0), .rx_byte(rx_byte), .rx_pop(rx_pop),
    .rd_valid(dma_rd_valid), .rd_data(dma_rd_data), .rd_ready(dma_rd_ready),
    .last_handoff(last_handoff)
  );

  // Frame counts as finished once every byte has left the TX FIFO.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_fin <= 1'b0;
    else        frame_fin <= all_sent && (tx_level == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ta_clear <= 1'b0;
    else        ta_clear <= frame_end || last_handoff;
  end

  dreq_thresh u_thr (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .tx_level(tx_level), .rx_level(rx_level), .frame_fin(frame_fin),
    .tx_dreq(tx_dreq), .rx_dreq(rx_dreq), .tx_panic(tx_panic), .rx_panic(rx_panic)
  );

  assert_frame_end_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> ta_clear);

  assert_last_word_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    last_handoff |=> ta_clear);

  assert_fin_needs_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_fin |-> $past(run));

endmodule

// File: tb/test_dma_req_gen.sv
module test_dma_req_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dma_en = 1'b0, xfer_active = 1'b0, frame_end = 1'b0, cfg_wr = 1'b0;
  logic [15:0] xfer_len = '0;
  logic [31:0] cfg_wdata = '0;
  logic [7:0]  tx_level = '0, rx_level = '0, rx_byte = '0;
  logic        tx_full = 1'b0, dma_wr_valid = 1'b0, dma_rd_ready = 1'b0;
  logic [31:0] dma_wr_data = '0;
  logic        tx_push, rx_pop, dma_wr_ready, dma_rd_valid;
  logic [7:0]  tx_byte;
  logic [31:0] dma_rd_data;
  logic        tx_dreq, rx_dreq, tx_panic, rx_panic, ta_clear;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dma_req_gen i_dma_req_gen (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .xfer_active(xfer_active),
    .xfer_len(xfer_len), .frame_end(frame_end), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .tx_level(tx_level), .rx_level(rx_level), .tx_full(tx_full),
    .tx_push(tx_push), .tx_byte(tx_byte), .rx_byte(rx_byte), .rx_pop(rx_pop),
    .dma_wr_valid(dma_wr_valid), .dma_wr_data(dma_wr_data), .dma_wr_ready(dma_wr_ready),
    .dma_rd_valid(dma_rd_valid), .dma_rd_data(dma_rd_data), .dma_rd_ready(dma_rd_ready),
    .tx_dreq(tx_dreq), .rx_dreq(rx_dreq), .tx_panic(tx_panic), .rx_panic(rx_panic),
    .ta_clear(ta_clear)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic levels(input logic [7:0] t, input logic [7:0] r, input int waits);
    tx_level = t;
    rx_level = r;
    repeat (waits) @(negedge clk);
    #1;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R7 reset tx_dreq", 32'(tx_dreq), 0);
    chk("R7 reset rx_dreq", 32'(rx_dreq), 0);
    chk("R7 reset panics", 32'({tx_panic, rx_panic}), 0);
    chk("R12 reset ta_clear", 32'(ta_clear), 0);
  endtask

  task automatic t_default_thresholds;
    @(negedge clk);
    dma_en = 1'b1;
    levels(8'h20, 8'h20, 1);
    chk("R2 tx at 0x20", 32'(tx_dreq), 1);
    chk("R3 tx above panic", 32'(tx_panic), 0);
    chk("R4 rx at 0x20", 32'(rx_dreq), 0);
    levels(8'h21, 8'h21, 1);
    chk("R2 tx at 0x21", 32'(tx_dreq), 0);
    chk("R4 rx at 0x21", 32'(rx_dreq), 1);
    levels(8'h10, 8'h30, 1);
    chk("R3 tx at 0x10", 32'(tx_panic), 1);
    chk("R5 rx at 0x30", 32'(rx_panic), 0);
    levels(8'h11, 8'h31, 1);
    chk("R3 tx at 0x11", 32'(tx_panic), 0);
    chk("R5 rx at 0x31", 32'(rx_panic), 1);
    chk("R1 default rx req kept", 32'(rx_dreq), 1);
  endtask

  task automatic t_load_thresholds;
    @(negedge clk);
    cfg_wdata = 32'h0A_05_03_07;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    levels(8'h07, 8'h05, 2);
    chk("R1 tx req loaded", 32'(tx_dreq), 1);
    chk("R1 rx req loaded", 32'(rx_dreq), 0);
    chk("R1 panics idle", 32'({tx_panic, rx_panic}), 0);
    levels(8'h03, 8'h0B, 1);
    chk("R1 tx panic loaded", 32'(tx_panic), 1);
    chk("R1 rx panic loaded", 32'(rx_panic), 1);
    chk("R1 rx req above", 32'(rx_dreq), 1);
    cfg_wdata = 32'h30_20_10_20;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic t_disabled;
    @(negedge clk);
    dma_en = 1'b0;
    xfer_active = 1'b1;
    xfer_len = 16'd8;
    dma_wr_valid = 1'b1;
    levels(8'h00, 8'h40, 2);
    chk("R7 tx_dreq off", 32'(tx_dreq), 0);
    chk("R7 rx_dreq off", 32'(rx_dreq), 0);
    chk("R7 panics off", 32'({tx_panic, rx_panic}), 0);
    chk("R7 no word accept", 32'(dma_wr_ready), 0);
    chk("R7 no pop", 32'(rx_pop), 0);
    chk("R7 no push", 32'(tx_push), 0);
    dma_wr_valid = 1'b0;
    xfer_active = 1'b0;
    rx_level = 8'h00;
    @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] w, input logic expect_ready, input string tag);
    @(negedge clk);
    dma_wr_valid = 1'b1;
    dma_wr_data = w;
    #1;
    chk(tag, 32'(dma_wr_ready), 32'(expect_ready));
    @(negedge clk);
    dma_wr_valid = 1'b0;
  endtask

  task automatic t_tx_split;
    logic [7:0] got [8];
    int n = 0;
    dma_en = 1'b1;
    xfer_active = 1'b1;
    xfer_len = 16'd6;
    tx_level = 8'h30;
    rx_level = 8'h00;
    dma_rd_ready = 1'b0;
    send_word(32'h44332211, 1'b1, "R8 first word accepted");
    #1;
    if (tx_push) begin got[n] = tx_byte; n++; end
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      tx_full = (i == 0 || i == 1);
      #1;
      if (tx_full) begin
        chk("R8 no push while full", 32'(tx_push), 0);
        chk("R8 byte held while full", 32'(tx_byte), 32'h22);
      end else if (tx_push && n < 8) begin
        got[n] = tx_byte;
        n++;
      end
    end
    tx_full = 1'b0;
    send_word(32'h88776655, 1'b1, "R9 second word accepted");
    #1;
    if (tx_push && n < 8) begin got[n] = tx_byte; n++; end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      if (tx_push && n < 8) begin got[n] = tx_byte; n++; end
    end
    chk("R9 byte count", 32'(n), 6);
    for (int i = 0; i < 6; i++) chk("R8 byte order", 32'(got[i]), 32'(8'h11 * (i + 1)));
    chk("R9 no further word", 32'(dma_wr_ready), 0);
  endtask

  task automatic t_rx_tail_request;
    // Continues the frame left by t_tx_split: all six bytes pushed.
    levels(8'h30, 8'h03, 8);
    chk("R6 rx quiet before drain", 32'(rx_dreq), 0);
    levels(8'h00, 8'h03, 3);
    chk("R6 rx request on finish", 32'(rx_dreq), 1);
    levels(8'h00, 8'h00, 1);
    chk("R6 rx request drops when empty", 32'(rx_dreq), 0);
    xfer_active = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_rx_pack;
    logic [31:0] words [2];
    int idx = 0;
    int nw = 0;
    int after = 0;
    xfer_len = 16'd6;
    tx_level = 8'h30;
    dma_rd_ready = 1'b1;
    xfer_active = 1'b1;
    for (int cyc = 0; cyc < 30; cyc++) begin
      @(negedge clk);
      rx_level = 8'(6 - idx);
      rx_byte = 8'hA1 + 8'(idx);
      #1;
      if (after == 1) chk("R12 pulse after last word", 32'(ta_clear), 1);
      if (after == 2) chk("R12 single pulse", 32'(ta_clear), 0);
      if (after != 0) after++;
      if (rx_pop) idx++;
      if (dma_rd_valid && nw < 2) begin
        words[nw] = dma_rd_data;
        nw++;
        if (nw == 2) after = 1;
      end
    end
    chk("R10 word count", 32'(nw), 2);
    chk("R10 first word", words[0], 32'hA4A3A2A1);
    chk("R11 padded word", words[1], 32'h0000A6A5);
    xfer_active = 1'b0;
    dma_rd_ready = 1'b0;
    rx_level = 8'h00;
    @(negedge clk);
  endtask

  task automatic t_clear_coincide;
    @(negedge clk);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    #1;
    chk("R12 frame_end pulse", 32'(ta_clear), 1);
    @(negedge clk); #1;
    chk("R12 frame_end pulse ends", 32'(ta_clear), 0);
    xfer_len = 16'd2;
    xfer_active = 1'b1;
    dma_rd_ready = 1'b0;
    begin
      int idx = 0;
      for (int cyc = 0; cyc < 6; cyc++) begin
        @(negedge clk);
        rx_level = 8'(2 - idx);
        rx_byte = 8'hB1 + 8'(idx);
        #1;
        if (rx_pop) idx++;
      end
    end
    chk("R11 short word offered", 32'(dma_rd_valid), 1);
    chk("R11 short word padded", dma_rd_data, 32'h0000B2B1);
    dma_rd_ready = 1'b1;
    frame_end = 1'b1;
    @(negedge clk);
    dma_rd_ready = 1'b0;
    frame_end = 1'b0;
    #1;
    chk("R12 coincident clear", 32'(ta_clear), 1);
    @(negedge clk); #1;
    chk("R12 coincident single pulse", 32'(ta_clear), 0);
    xfer_active = 1'b0;
  endtask

  initial begin
    t_reset();
    t_default_thresholds();
    t_load_thresholds();
    t_disabled();
    t_tx_split();
    t_rx_tail_request();
    t_rx_pack();
    t_clear_coincide();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule